// File: doc/BRIEF.md
# Reversible-Gate Unsigned Array Multiplier

This block multiplies two unsigned operands of `W` bits each (4 by default) and gives a product of `2W` bits. It has no clock, and every function inside it is built from reversible primitives. Each primitive is a bijective module with as many outputs as inputs. No net may feed more than one gate input, so each operand bit is copied first through a chain of double-XOR copy gates. A single-bit XOR copy variant is also available. Every partial product is then formed by a Peres gate whose third input is tied low.

The partial-product rows are added by a carry-save array of half and full adders, which leaves two rows. A ripple carry-propagate row then adds those two rows to give the upper half of the product. Each half adder is one Peres gate. Each full adder is two cascaded Peres gates. All constant inputs are literal zeros inside the block. Every output that the arithmetic does not use is gathered onto a garbage bus, so the cost of reversibility can be seen and counted at the ports.

Top module: `rev_mult`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `a * b` as a `2W`-bit value.
- R2: The Peres primitive maps inputs (x, y, z) to outputs p = x, q = x XOR y, r = (x AND y) XOR z.
- R3: The single-copy primitive maps inputs (x, y) to outputs p = x, q = x XOR y.
- R4: The double-copy primitive maps inputs (w, x, y, z) to outputs p = w, q = w XOR x, r = y, s = y XOR z.
- R5: Each of the three primitives is a bijection: across all of its input codes, no two input codes give the same output code.
- R6: The two-Peres full-adder cell gives sum = a XOR b XOR cin and cout = majority(a, b, cin). Its two garbage bits are g[0] = a and g[1] = a XOR b.
- R7: The garbage bus has 2W² + W + 2W(W−2) bits, which is 52 when W = 4. This is two bits per partial-product gate, one bit per half adder and two bits per full adder.
- R8: For the partial-product gate with index k = i·W + j (operand bit a[j], operand bit b[i]), garbage bit 2k equals a[j] and garbage bit 2k+1 equals a[j] XOR b[i].
- R9: With both operands at their maximum (15 × 15 when W = 4), the product is 225 and the top product bit is set. A zero operand on either side gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| product | output | 2W | Unsigned product a·b |
| garbage | output | 2W² + W + 2W(W−2) | Unused primitive outputs; partial-product gates occupy the low bits |

## Verification
A primitive cannot be fed an input code directly from the multiplier ports, because the constant-zero inputs hold every gate inside a narrow subset of its codes. The bench therefore places each primitive and the full-adder cell on its own and drives all of its input codes. For each code it checks the mapping and marks the output code as used, so a repeated output code shows up as a failed bijection. The multiplier itself receives every one of the 256 operand pairs. This drives each carry chain through its longest ripple, including the 15 × 15 case where the final carry sets the top bit.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

   // number of garbage bits for a W x W multiplier
   function automatic int garb_bits(input int w);
      return 2 * w * w + w + 2 * w * (w - 2);
   endfunction

   // number of full-adder cells in the addition network
   function automatic int fa_cells(input int w);
      return w * (w - 2);
   endfunction

endpackage

// File: rtl/rev_feynman.sv
module rev_feynman (
   input  logic x,
   input  logic y,
   output logic p,
   output logic q
);
   assign p = x;
   assign q = x ^ y;

   always_comb begin
      if (!$isunknown({x, y})) begin
         // R3
         feyn_inv_chk: assert ({p, p ^ q} == {x, y});
      end
   end
endmodule

// File: rtl/rev_copy4.sv
module rev_copy4 (
   input  logic w,
   input  logic x,
   input  logic y,
   input  logic z,
   output logic p,
   output logic q,
   output logic r,
   output logic s
);
   assign p = w;
   assign q = w ^ x;
   assign r = y;
   assign s = y ^ z;

   always_comb begin
      if (!$isunknown({w, x, y, z})) begin
         // R4
         copy_inv_chk: assert ({p, p ^ q, r, r ^ s} == {w, x, y, z});
      end
   end
endmodule

// File: rtl/rev_peres.sv
module rev_peres (
   input  logic x,
   input  logic y,
   input  logic z,
   output logic p,
   output logic q,
   output logic r
);
   assign p = x;
   assign q = x ^ y;
   assign r = (x & y) ^ z;

   always_comb begin
      if (!$isunknown({x, y, z})) begin
         // R5
         peres_inv_chk: assert ({p, p ^ q, r ^ (p & (p ^ q))} == {x, y, z});
      end
   end
endmodule

// File: rtl/rev_fa.sv
module rev_fa (
   input  logic       a,
   input  logic       b,
   input  logic       cin,
   output logic       sum,
   output logic       cout,
   output logic [1:0] g
);
   logic axb, anb;

   rev_peres u_first (
      .x(a), .y(b), .z(1'b0),
      .p(g[0]), .q(axb), .r(anb)
   );

   rev_peres u_second (
      .x(axb), .y(cin), .z(anb),
      .p(g[1]), .q(sum), .r(cout)
   );

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         // R6
         fa_sum_chk: assert ({cout, sum} == 2'({1'b0, a} + {1'b0, b} + {1'b0, cin}));
      end
   end
endmodule

// File: rtl/rev_fanout.sv
module rev_fanout #(
   parameter int W      = 4,
   parameter bit PAIRED = 1'b1
) (
   input  logic                  a,
   input  logic [W-1:0]          a_in,
   input  logic [W-1:0]          b_in,
   output logic [W-1:0][W-1:0]   a_cp,
   output logic [W-1:0][W-1:0]   b_cp
);
   // a is a dummy tie so the module has a scalar anchor; unused by design
   logic [W-1:0] va [W];
   logic [W-1:0] vb [W];
   logic         unused_a;

   assign unused_a = a;
   assign va[0] = a_in;
   assign vb[0] = b_in;

   for (genvar k = 0; k < W - 1; k++) begin : g_stage
      for (genvar j = 0; j < W; j++) begin : g_bit
         if (PAIRED) begin : g_pair
            rev_copy4 u_cp (
               .w(va[k][j]), .x(1'b0), .y(vb[k][j]), .z(1'b0),
               .p(a_cp[k][j]), .q(va[k+1][j]),
               .r(b_cp[k][j]), .s(vb[k+1][j])
            );
         end else begin : g_single
            rev_feynman u_fa (
               .x(va[k][j]), .y(1'b0), .p(a_cp[k][j]), .q(va[k+1][j])
            );
            rev_feynman u_fb (
               .x(vb[k][j]), .y(1'b0), .p(b_cp[k][j]), .q(vb[k+1][j])
            );
         end
      end
   end

   assign a_cp[W-1] = va[W-1];
   assign b_cp[W-1] = vb[W-1];
endmodule

// File: rtl/rev_ppgen.sv
module rev_ppgen #(
   parameter int W = 4
) (
   input  logic [W-1:0][W-1:0]   a_cp,
   input  logic [W-1:0][W-1:0]   b_cp,
   output logic [W-1:0][W-1:0]   pp,
   output logic [2*W*W-1:0]      g_pp
);
   // pp[i][j] = a[j] & b[i]; gate index k = i*W + j
   for (genvar i = 0; i < W; i++) begin : g_row
      for (genvar j = 0; j < W; j++) begin : g_col
         rev_peres u_and (
            .x(a_cp[i][j]), .y(b_cp[j][i]), .z(1'b0),
            .p(g_pp[2*(i*W+j)]), .q(g_pp[2*(i*W+j)+1]), .r(pp[i][j])
         );
      end
   end
endmodule

// File: rtl/rev_addarray.sv
module rev_addarray #(
   parameter int W = 4
) (
   input  logic [W-1:0][W-1:0]             pp,
   output logic [2*W-1:0]                  prod,
   output logic [W-1:0]                    g_ha,
   output logic [2*rmul_pkg::fa_cells(W)-1:0] g_fa
);
   localparam int ROWFA = (W - 2) * (W - 1);

   logic [W-2:0] srow [W-1];
   logic [W-2:0] crow [W-1];
   logic [W-2:0] cc;

   assign prod[0] = pp[0][0];

   // first carry-save row: half adders
   for (genvar j = 0; j < W - 1; j++) begin : g_ha_row
      rev_peres u_ha (
         .x(pp[1][j]), .y(pp[0][j+1]), .z(1'b0),
         .p(g_ha[j]), .q(srow[0][j]), .r(crow[0][j])
      );
   end

   // remaining carry-save rows: full adders
   for (genvar i = 2; i < W; i++) begin : g_csa
      for (genvar j = 0; j < W - 1; j++) begin : g_cell
         logic opnd;
         if (j == W - 2) begin : g_edge
            assign opnd = pp[i-1][W-1];
         end else begin : g_mid
            assign opnd = srow[i-2][j+1];
         end
         rev_fa u_fa (
            .a(pp[i][j]), .b(opnd), .cin(crow[i-2][j]),
            .sum(srow[i-1][j]), .cout(crow[i-1][j]),
            .g(g_fa[2*((i-2)*(W-1)+j)+1 : 2*((i-2)*(W-1)+j)])
         );
      end
   end

   for (genvar i = 1; i < W; i++) begin : g_low
      assign prod[i] = srow[i-1][0];
   end

   // carry-propagate row
   for (genvar k = 0; k < W - 1; k++) begin : g_cpa
      logic opnd;
      if (k == W - 2) begin : g_edge
         assign opnd = pp[W-1][W-1];
      end else begin : g_mid
         assign opnd = srow[W-2][k+1];
      end
      if (k == 0) begin : g_first
         rev_peres u_ha (
            .x(opnd), .y(crow[W-2][0]), .z(1'b0),
            .p(g_ha[W-1]), .q(prod[W]), .r(cc[0])
         );
      end else begin : g_next
         rev_fa u_fa (
            .a(opnd), .b(crow[W-2][k]), .cin(cc[k-1]),
            .sum(prod[W+k]), .cout(cc[k]),
            .g(g_fa[2*(ROWFA+k-1)+1 : 2*(ROWFA+k-1)])
         );
      end
   end

   assign prod[2*W-1] = cc[W-2];
endmodule

// File: rtl/rev_mult.sv
module rev_mult #(
   parameter int W      = 4,
   parameter bit PAIRED = 1'b1,
   localparam int PW    = 2 * W,
   localparam int GW    = rmul_pkg::garb_bits(W)
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [PW-1:0] product,
   output logic [GW-1:0] garbage
);
   localparam int PPG = 2 * W * W;
   localparam int FAG = 2 * rmul_pkg::fa_cells(W);

   if (W < 3) begin : g_bad_width
      $error("rev_mult: W must be at least 3");
   end

   logic [W-1:0][W-1:0] a_cp, b_cp, pp;
   logic [PPG-1:0]      g_pp;
   logic [W-1:0]        g_ha;
   logic [FAG-1:0]      g_fa;

   rev_fanout #(.W(W), .PAIRED(PAIRED)) u_fan (
      .a(1'b0), .a_in(a), .b_in(b), .a_cp(a_cp), .b_cp(b_cp)
   );

   rev_ppgen #(.W(W)) u_pp (
      .a_cp(a_cp), .b_cp(b_cp), .pp(pp), .g_pp(g_pp)
   );

   rev_addarray #(.W(W)) u_add (
      .pp(pp), .prod(product), .g_ha(g_ha), .g_fa(g_fa)
   );

   assign garbage = {g_fa, g_ha, g_pp};

   always_comb begin
      if (!$isunknown({a, b})) begin
         // R1
         product_chk: assert (product == PW'(a) * PW'(b));
         for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
               // R8
               pp_garb_chk: assert (garbage[2*(i*W+j)] == a[j] &&
                                    garbage[2*(i*W+j)+1] == (a[j] ^ b[i]));
            end
         end
      end
   end
endmodule

// File: tb/rev_mult_test.sv
module rev_mult_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // multiplier
   logic [3:0]  op_a = '0, op_b = '0;
   logic [7:0]  prod;
   logic [51:0] garb;

   rev_mult #(.W(4)) uut (.a(op_a), .b(op_b), .product(prod), .garbage(garb));

   // standalone primitives
   logic px, py, pz, pp_, pq, pr;
   rev_peres t_peres (.x(px), .y(py), .z(pz), .p(pp_), .q(pq), .r(pr));
   logic fx, fy, fp, fq;
   rev_feynman t_feyn (.x(fx), .y(fy), .p(fp), .q(fq));
   logic cw, cx, cy, cz, cp, cq, cr, cs;
   rev_copy4 t_copy (.w(cw), .x(cx), .y(cy), .z(cz), .p(cp), .q(cq), .r(cr), .s(cs));
   logic ea, eb, ec, esum, ecout;
   logic [1:0] eg;
   rev_fa t_fa (.a(ea), .b(eb), .cin(ec), .sum(esum), .cout(ecout), .g(eg));

   typedef struct packed {
      logic [3:0] a;
      logic [3:0] b;
      logic [7:0] e;
   } item_t;
   item_t sb[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: pushes expected item into scoreboard
   task automatic drive(input logic [3:0] x, input logic [3:0] y);
      @(posedge clk);
      #1;
      op_a = x;
      op_b = y;
      sb.push_back('{a: x, b: y, e: 8'(x) * 8'(y)});
   endtask

   // monitor
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic ok8;
         it = sb.pop_front();
         if (it.a == 4'hF && it.b == 4'hF)
            check(prod == 8'd225 && prod[7], "R9 max", int'(prod), 225);
         else if (it.a == 0 || it.b == 0)
            check(prod == 8'd0, "R9 zero", int'(prod), 0);
         check(prod == it.e, "R1 product", int'(prod), int'(it.e));
         ok8 = 1'b1;
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               if (garb[2*(i*4+j)] != it.a[j] ||
                   garb[2*(i*4+j)+1] != (it.a[j] ^ it.b[i])) ok8 = 1'b0;
         check(ok8 == 1'b1, "R8 garbage layout", int'(garb[31:0]), -1);
      end
   end

   initial begin
      logic [7:0]  seen8;
      logic [3:0]  seen4;
      logic [15:0] seen16;

      // R7: garbage width
      check($bits(uut.garbage) == 52, "R7 garbage width", $bits(uut.garbage), 52);

      // R2 / R5: Peres
      seen8 = '0;
      for (int v = 0; v < 8; v++) begin
         {px, py, pz} = 3'(v);
         #1;
         check({pp_, pq, pr} == {px, px ^ py, (px & py) ^ pz}, "R2 peres map",
               int'({pp_, pq, pr}), int'({px, px ^ py, (px & py) ^ pz}));
         check(!seen8[{pp_, pq, pr}], "R5 peres bijection", int'({pp_, pq, pr}), -1);
         seen8[{pp_, pq, pr}] = 1'b1;
      end

      // R3 / R5: single copy
      seen4 = '0;
      for (int v = 0; v < 4; v++) begin
         {fx, fy} = 2'(v);
         #1;
         check({fp, fq} == {fx, fx ^ fy}, "R3 feynman map", int'({fp, fq}), int'({fx, fx ^ fy}));
         check(!seen4[{fp, fq}], "R5 feynman bijection", int'({fp, fq}), -1);
         seen4[{fp, fq}] = 1'b1;
      end

      // R4 / R5: double copy
      seen16 = '0;
      for (int v = 0; v < 16; v++) begin
         {cw, cx, cy, cz} = 4'(v);
         #1;
         check({cp, cq, cr, cs} == {cw, cw ^ cx, cy, cy ^ cz}, "R4 copy map",
               int'({cp, cq, cr, cs}), int'({cw, cw ^ cx, cy, cy ^ cz}));
         check(!seen16[{cp, cq, cr, cs}], "R5 copy bijection", int'({cp, cq, cr, cs}), -1);
         seen16[{cp, cq, cr, cs}] = 1'b1;
      end

      // R6: full-adder cell
      for (int v = 0; v < 8; v++) begin
         {ea, eb, ec} = 3'(v);
         #1;
         check({ecout, esum} == 2'(int'(ea) + int'(eb) + int'(ec)), "R6 fa sum",
               int'({ecout, esum}), int'(ea) + int'(eb) + int'(ec));
         check(eg == {ea ^ eb, ea}, "R6 fa garbage", int'(eg), int'({ea ^ eb, ea}));
      end

      // R1 / R8 / R9: all operand pairs
      for (int x = 0; x < 16; x++)
         for (int y = 0; y < 16; y++)
            drive(4'(x), 4'(y));
      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule